// File: doc/BRIEF.md
# Audio Oversampling Clock Divider

This block divides a fast audio reference clock down to the codec master-clock rate. The reference runs at one of two multiples of the sample rate fs: 512·fs or 384·fs, chosen by a family-select input. A 3-bit power-of-two code sets the division. The block does not make a second clock. It produces a single-cycle enable, `mclk_en`, in the reference domain. The enable fires once every 2^code reference cycles, so with code 0 it is high on every cycle and the reference passes straight through. Downstream logic either gates the reference clock with this enable or uses it as a clock enable.

The block also reports the ratio it is producing, in units of fs, and raises an error flag when the requested setting belongs to neither family. A new code or family applied while running is loaded only once the current output period has ended. While the run input is low, settings are loaded on every cycle and the output stays quiet. Sample rates from 8 kHz to 192 kHz are served by choosing the reference frequency. The divider itself does not depend on the sample rate.

Top module: `audio_osr_div`

## Requirements
- R1: With family select 0 (reference = 512·fs), codes 0, 1, 2, 3 and 4 are legal. `mclk_ratio` reads 512, 256, 128, 64 and 32 respectively, and `mclk_en` pulses once every 2^code cycles.
- R2: With family select 1 (reference = 384·fs), codes 0, 1, 2 and 3 are legal. `mclk_ratio` reads 384, 192, 96 and 48 respectively, and `mclk_en` pulses once every 2^code cycles.
- R3: A setting outside both families raises `ratio_err` and holds `mclk_en` low and `mclk_ratio` at 0. The illegal settings are code 4 with family select 1, and codes 5 to 7 with either family.
- R4: `mclk_en` is low in every cycle in which `run` is low. In the first cycle that `run` is seen high with a legal loaded setting, `mclk_en` is high.
- R5: A new code requested while running takes effect only after the current output period completes. The interval between consecutive pulses is the old period first and the new period after that, so no short pulse gap appears.
- R6: While `run` is low, a changed code or family is loaded at the next clock edge and is visible on `mclk_ratio` and `ratio_err` one cycle later.
- R7: While running in the error state, a legal request is loaded at the next edge, and `mclk_en` pulses in that next cycle.
- R8: After reset, `mclk_en` is 0, `ratio_err` is 0 and `mclk_ratio` is 512 (code 0, family 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at 512·fs or 384·fs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run | input | 1 | Enables the master clock output |
| base_384 | input | 1 | Family select: 0 = 512·fs reference, 1 = 384·fs reference |
| mult_code | input | 3 | Power-of-two divide code |
| mclk_en | output | 1 | One-cycle master clock enable, once per 2^code cycles |
| mclk_ratio | output | 10 | Ratio being produced, in multiples of fs; 0 in error |
| ratio_err | output | 1 | Loaded setting is outside both families |

## Verification
The assertions assume that `run`, `base_384` and `mult_code` are synchronous to `clk` and settle before each rising edge. They do not assume that settings are stable while running. The mid-period change checks depend on changes being allowed at any time. The stimulus drives every input on the falling edge and samples outputs one time unit later. Settings therefore change at arbitrary counter phases, including in the middle of a period and during the error state.

// File: rtl/audio_osr_div_pkg.sv
package audio_osr_div_pkg;

  localparam int unsigned CODE_W  = 3;
  localparam int unsigned RATIO_W = 10;

  typedef enum logic {
    FAM_512 = 1'b0,
    FAM_384 = 1'b1
  } family_e;

  typedef struct packed {
    logic [CODE_W-1:0]  code;
    logic               ok;
    logic [RATIO_W-1:0] ratio;
  } osr_setting_t;

endpackage

// File: rtl/osr_cfg_decode.sv
module osr_cfg_decode
  import audio_osr_div_pkg::*;
#(
  parameter int unsigned MAX_CODE_512 = 4,
  parameter int unsigned MAX_CODE_384 = 3,
  parameter int unsigned BASE_512     = 512,
  parameter int unsigned BASE_384     = 384
) (
  input  logic              family,
  input  logic [CODE_W-1:0] code,
  output osr_setting_t      setting
);

  logic                family_ok;
  logic [RATIO_W-1:0]  base_ratio;

  always_comb begin
    if (family == FAM_384) begin
      family_ok  = (32'(code) <= MAX_CODE_384);
      base_ratio = RATIO_W'(BASE_384);
    end else begin
      family_ok  = (32'(code) <= MAX_CODE_512);
      base_ratio = RATIO_W'(BASE_512);
    end
    setting.code  = code;
    setting.ok    = family_ok;
    setting.ratio = family_ok ? (base_ratio >> code) : '0;
  end

endmodule

// File: rtl/osr_period_counter.sv
module osr_period_counter
  import audio_osr_div_pkg::*;
#(
  parameter int unsigned MAX_CODE = 4,
  localparam int unsigned CNT_W   = (MAX_CODE < 1) ? 1 : MAX_CODE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  osr_setting_t req,
  output osr_setting_t cur,
  output logic         tick,
  output logic         period_end
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  osr_setting_t     cur_q, cur_d;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last_cnt;

  // Last counter value of the loaded period: 2^code - 1
  always_comb begin
    span     = (CNT_W+1)'(1) << cur_q.code;
    last_cnt = CNT_W'(span - 1'b1);
  end

  always_comb begin
    period_end = !cur_q.ok || (cnt_q == last_cnt);
    cnt_d      = cnt_q;
    cur_d      = cur_q;
    if (!run || period_end) begin
      cnt_d = '0;
      cur_d = req;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      cur_q.code  <= '0;
      cur_q.ok    <= 1'b1;
      cur_q.ratio <= RATIO_W'(512);
    end else begin
      cnt_q <= cnt_d;
      cur_q <= cur_d;
    end
  end

  assign cur  = cur_q;
  assign tick = run && cur_q.ok && (cnt_q == '0);

endmodule

// File: rtl/audio_osr_div.sv
module audio_osr_div
  import audio_osr_div_pkg::*;
#(
  parameter int unsigned MAX_CODE_512 = 4,
  parameter int unsigned MAX_CODE_384 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               base_384,
  input  logic [CODE_W-1:0]  mult_code,
  output logic               mclk_en,
  output logic [RATIO_W-1:0] mclk_ratio,
  output logic               ratio_err
);

  localparam int unsigned MAX_CODE =
    (MAX_CODE_512 > MAX_CODE_384) ? MAX_CODE_512 : MAX_CODE_384;

  osr_setting_t req_set;
  osr_setting_t cur_set;
  logic         tick;
  logic         period_end;

  osr_cfg_decode #(
    .MAX_CODE_512 (MAX_CODE_512),
    .MAX_CODE_384 (MAX_CODE_384)
  ) u_dec (
    .family  (base_384),
    .code    (mult_code),
    .setting (req_set)
  );

  osr_period_counter #(
    .MAX_CODE (MAX_CODE)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .req        (req_set),
    .cur        (cur_set),
    .tick       (tick),
    .period_end (period_end)
  );

  assign mclk_en    = tick;
  assign mclk_ratio = cur_set.ratio;
  assign ratio_err  = !cur_set.ok;

endmodule

// File: rtl/audio_osr_div_chk.sv
module audio_osr_div_chk
  import audio_osr_div_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               mclk_en,
  input logic [RATIO_W-1:0] mclk_ratio,
  input logic               ratio_err,
  input logic               period_end
);

  AST_EN_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |-> run); // R4

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> (!mclk_en && mclk_ratio == '0)); // R3

  AST_START_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run) && !ratio_err) |-> mclk_en); // R4

  AST_CHANGE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(mclk_ratio)) |-> $past(period_end)); // R5

  AST_BACK_TO_BACK_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_en && $past(mclk_en) && $past(mclk_ratio) == mclk_ratio)
      |-> (mclk_ratio == 10'd512 || mclk_ratio == 10'd384)); // R1

endmodule

bind audio_osr_div audio_osr_div_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .mclk_en    (mclk_en),
  .mclk_ratio (mclk_ratio),
  .ratio_err  (ratio_err),
  .period_end (period_end)
);

// File: tb/tb_audio_osr_div.sv
module tb_audio_osr_div;

  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 64;

  logic       clk;
  logic       rst_n;
  logic       run;
  logic       base_384;
  logic [2:0] mult_code;
  logic       mclk_en;
  logic [9:0] mclk_ratio;
  logic       ratio_err;

  int checks = 0;
  int errors = 0;

  audio_osr_div dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .base_384   (base_384),
    .mult_code  (mult_code),
    .mclk_en    (mclk_en),
    .mclk_ratio (mclk_ratio),
    .ratio_err  (ratio_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Advance to next falling edge, then settle
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Load a setting with run low and wait until it is visible
  task automatic load(input logic fam, input logic [2:0] code);
    run = 1'b0; base_384 = fam; mult_code = code;
    step();
    step();
  endtask

  function automatic int exp_ratio(input logic fam, input int code);
    if (fam) return (code <= 3) ? (384 >> code) : 0;
    return (code <= 4) ? (512 >> code) : 0;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; run = 1'b0; base_384 = 1'b0; mult_code = 3'd0;
    step(); step();
    check("R8 en", int'(mclk_en), 0);
    check("R8 err", int'(ratio_err), 0);
    check("R8 ratio", int'(mclk_ratio), 512);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_family(input logic fam, input int maxc, input string req);
    for (int c = 0; c <= maxc; c++) begin
      int n;
      load(fam, 3'(c));
      check({req, " ratio"}, int'(mclk_ratio), exp_ratio(fam, c));
      check({req, " err"}, int'(ratio_err), 0);
      run = 1'b1;
      #1;
      check("R4 first tick", int'(mclk_en), 1);
      n = 0;
      for (int i = 0; i < WINDOW; i++) begin
        if (mclk_en) n++;
        step();
      end
      check({req, " tick count"}, n, WINDOW >> c);
      run = 1'b0;
      step();
    end
  endtask

  task automatic t_illegal(input logic fam, input logic [2:0] code);
    int n;
    load(fam, code);
    check("R3 err", int'(ratio_err), 1);
    check("R3 ratio", int'(mclk_ratio), 0);
    run = 1'b1;
    n = 0;
    for (int i = 0; i < 16; i++) begin
      #1;
      if (mclk_en) n++;
      step();
    end
    check("R3 ticks", n, 0);
    // R7: legal request while running in error state
    mult_code = 3'd2; base_384 = 1'b0;
    step();
    check("R7 en", int'(mclk_en), 1);
    check("R7 err", int'(ratio_err), 0);
    run = 1'b0;
    step();
  endtask

  task automatic t_run_gate();
    int n;
    load(1'b0, 3'd2);
    run = 1'b1;
    step(); step();
    run = 1'b0;
    #1;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (mclk_en) n++;
      step();
    end
    check("R4 gated", n, 0);
    mult_code = 3'd1; base_384 = 1'b1;
    step();
    check("R6 ratio", int'(mclk_ratio), 192);
  endtask

  task automatic t_change();
    int last_t, t, k;
    int iv[3];
    load(1'b0, 3'd1);
    run = 1'b1;
    #1;
    // tick now at t=0; request change at this phase
    mult_code = 3'd3;
    last_t = 0; k = 0;
    for (t = 1; t < 40 && k < 3; t++) begin
      step();
      if (mclk_en) begin
        iv[k] = t - last_t;
        last_t = t;
        k++;
      end
    end
    check("R5 pulses seen", k, 3);
    check("R5 old period", iv[0], 2);
    check("R5 new period a", iv[1], 8);
    check("R5 new period b", iv[2], 8);
    check("R5 ratio", int'(mclk_ratio), 64);
    run = 1'b0;
    step();
  endtask

  initial begin
    t_reset();
    t_family(1'b0, 4, "R1");
    t_family(1'b1, 3, "R2");
    t_illegal(1'b1, 3'd4);
    t_illegal(1'b0, 3'd5);
    t_illegal(1'b1, 3'd7);
    t_run_gate();
    t_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule